// File: doc/BRIEF.md
# Linked-Channel Double-Buffered PWM Generator

This block produces one pulse-width-modulated output from a free-running up-counter that wraps at a programmable period value. Two 16-bit compare registers serve that output. In the single-channel mode only the first compare register sets the pulse edge. In the paired mode the two registers take turns. Whichever register software wrote most recently becomes the active pulse-width source at the next counter wrap, so a new width can be staged in the idle register without glitching the period that is running.

Software reaches the block through one byte-wide write port. Every 16-bit value is written high byte first and low byte last, and only the low-byte write commits the value. The output is built from two actions. The counter wrap can toggle the pin. A compare match drives the pin to a fixed level. The pulse is therefore the stretch between the wrap and the match.

Top module: `lpwm_top`

## Requirements
- R1: The counter steps from 0 up to the period value and then returns to 0, so one period lasts period+1 clock cycles. The period value is at byte addresses 1 (high) and 2 (low).
- R2: Writing address 0 with bit 0 set halts the counter, and while halted neither the count nor `pwm_out` changes. Writing it with bit 0 clear lets the counter run.
- R3: Writing address 0 with bit 1 set clears the counter to 0, points the active source back at compare register 0, and sets `pwm_out` to the level given by edge-select bit 0.
- R4: Compare register 0 is at addresses 3/4 and compare register 1 is at 5/6. A high-byte write alone changes nothing. The low-byte write commits both bytes together.
- R5: The channel control byte is at address 7, laid out as bits[1:0] mode, bit 2 toggle-on-wrap and bits[4:3] edge select. With edge select 2'b10 a match drives the output low, and with 2'b11 a match drives it high.
- R6: With toggle-on-wrap set, the output inverts on every counter wrap. With it clear, the wrap leaves the output alone.
- R7: When the compare value equals the period value, the match action wins over the wrap toggle, which gives a constant level. When the compare value exceeds the period value, no match ever occurs.
- R8: Mode 2'b01 is single-channel: only compare register 0 sets the pulse, whatever is written to register 1.
- R9: Mode 2'b10 is paired. Register 0 is the source until register 1 is written. A write to the idle register takes effect only at the next wrap, and at each wrap the register written last becomes the source. A write to address 7 makes register 0 the latest again.
- R10: In paired mode, a write to the register that is currently the source changes the compare value within the running period.
- R11: Writes to address 8 (the second channel's control byte) have no effect on the output.
- R12: A synchronous active-high reset leaves `pwm_out` low, the counter halted at 0 and all mode bits clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_addr | input | 4 | Byte address of the write |
| wr_data | input | 8 | Byte written |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The single-channel path is driven with compare values below, equal to and above the period, under both edge polarities, with and without toggle-on-wrap, and with a period above 255. The high-time counted over two whole periods separates a correct match position from an off-by-one. It also separates the compare-wins-on-wrap rule from the toggle-only behaviour of an out-of-range compare. In a paired run, writes land in the idle register, in the active register, in the second control byte and as a lone high byte. The high-time of each period then shows whether a change arrived at once, one wrap later or never. Further directed runs cover clear-while-running, halt-while-high and the pointer reset on a control write.

// File: rtl/lpwm_pkg.sv
package lpwm_pkg;

  localparam int ADR_CTRL   = 0;
  localparam int ADR_PERIOD = 1;
  localparam int ADR_CMP0   = 3;
  localparam int ADR_CMP1   = 5;
  localparam int ADR_CH0CTL = 7;
  localparam int NUM_WIDE   = 3;

  typedef enum logic [1:0] {
    MD_OFF    = 2'b00,
    MD_SINGLE = 2'b01,
    MD_PAIR   = 2'b10,
    MD_RSVD   = 2'b11
  } mode_e;

  typedef struct packed {
    logic [1:0] edge_sel;
    logic       tov;
    mode_e      mode;
  } chctl_t;

endpackage

// File: rtl/lpwm_regs.sv
module lpwm_regs
  import lpwm_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic            halt,
  output logic            clr,
  output logic            ctl_wr,
  output logic            c0_commit,
  output logic            c1_commit,
  output logic [2*DW-1:0] period,
  output logic [2*DW-1:0] cmp0,
  output logic [2*DW-1:0] cmp1,
  output chctl_t          ch0ctl
);

  localparam int CW = 2 * DW;

  logic [CW-1:0] wide_q [NUM_WIDE];
  logic          halt_q;
  chctl_t        ctl_q;

  // each wide register: high byte is held, low byte write commits both
  for (genvar k = 0; k < NUM_WIDE; k++) begin : g_wide
    logic [DW-1:0] hold_q;
    logic          hi_w;
    logic          lo_w;
    assign hi_w = wr_en && (wr_addr == AW'(ADR_PERIOD + 2 * k));
    assign lo_w = wr_en && (wr_addr == AW'(ADR_PERIOD + 2 * k + 1));
    always_ff @(posedge clk) begin
      if (rst) begin
        hold_q    <= '0;
        wide_q[k] <= '1;
      end else begin
        if (hi_w) hold_q <= wr_data;
        if (lo_w) wide_q[k] <= {hold_q, wr_data};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q <= 1'b1;
      ctl_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(ADR_CTRL))   halt_q <= wr_data[0];
      if (wr_addr == AW'(ADR_CH0CTL)) ctl_q  <= chctl_t'(wr_data[4:0]);
    end
  end

  assign clr       = wr_en && (wr_addr == AW'(ADR_CTRL)) && wr_data[1];
  assign ctl_wr    = wr_en && (wr_addr == AW'(ADR_CH0CTL));
  assign c0_commit = wr_en && (wr_addr == AW'(ADR_CMP0 + 1));
  assign c1_commit = wr_en && (wr_addr == AW'(ADR_CMP1 + 1));
  assign halt      = halt_q;
  assign ch0ctl    = ctl_q;
  assign period    = wide_q[0];
  assign cmp0      = wide_q[1];
  assign cmp1      = wide_q[2];

endmodule

// File: rtl/lpwm_counter.sv
module lpwm_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          halt,
  input  logic          clr,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt,
  output logic          wrap
);

  logic [CW-1:0] cnt_q;

  assign wrap = !halt && (cnt_q == period);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (wrap)   cnt_q <= '0;
    else if (!halt)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/lpwm_chan.sv
module lpwm_chan
  import lpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          halt,
  input  logic          clr,
  input  logic          ctl_wr,
  input  logic          c0_commit,
  input  logic          c1_commit,
  input  logic          wrap,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cmp0,
  input  logic [CW-1:0] cmp1,
  input  chctl_t        ctl,
  output logic          act,
  output logic          hit,
  output logic          pwm_out
);

  logic          last_q;
  logic          act_q;
  logic          out_q;
  logic          pair;
  logic          drive;
  logic [CW-1:0] cmp_sel;

  assign pair    = (ctl.mode == MD_PAIR);
  assign drive   = (ctl.mode == MD_SINGLE) || pair;
  assign cmp_sel = act_q ? cmp1 : cmp0;
  assign hit     = !halt && drive && ctl.edge_sel[1] && (cnt == cmp_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b0;
      act_q  <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      if (ctl_wr)         last_q <= 1'b0;
      else if (c1_commit) last_q <= 1'b1;
      else if (c0_commit) last_q <= 1'b0;

      if (clr || ctl_wr)  act_q <= 1'b0;
      else if (wrap)      act_q <= pair && last_q;

      if (clr)            out_q <= ctl.edge_sel[0];
      else if (hit)       out_q <= ctl.edge_sel[0];
      else if (wrap && ctl.tov && drive) out_q <= ~out_q;
    end
  end

  assign act     = act_q;
  assign pwm_out = out_q;

endmodule

// File: rtl/lpwm_top.sv
module lpwm_top
  import lpwm_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          pwm_out
);

  localparam int CW = 2 * DW;

  logic          halt, clr, ctl_wr, c0_commit, c1_commit;
  logic          wrap, act, hit;
  logic [CW-1:0] period, cmp0, cmp1, cnt;
  chctl_t        ch0ctl;
  mode_e         ch0_mode;

  assign ch0_mode = ch0ctl.mode;

  lpwm_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .halt(halt), .clr(clr), .ctl_wr(ctl_wr), .c0_commit(c0_commit),
    .c1_commit(c1_commit), .period(period), .cmp0(cmp0), .cmp1(cmp1),
    .ch0ctl(ch0ctl)
  );

  lpwm_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .halt(halt), .clr(clr), .period(period),
    .cnt(cnt), .wrap(wrap)
  );

  lpwm_chan #(.CW(CW)) u_chan (
    .clk(clk), .rst(rst), .halt(halt), .clr(clr), .ctl_wr(ctl_wr),
    .c0_commit(c0_commit), .c1_commit(c1_commit), .wrap(wrap), .cnt(cnt),
    .cmp0(cmp0), .cmp1(cmp1), .ctl(ch0ctl), .act(act), .hit(hit),
    .pwm_out(pwm_out)
  );

endmodule

// File: rtl/lpwm_chk.sv
module lpwm_chk
  import lpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          halt,
  input logic          clr,
  input logic          ctl_wr,
  input logic          wrap,
  input logic          hit,
  input logic          act,
  input logic [CW-1:0] cnt,
  input mode_e         mode,
  input logic          pwm_out
);

  // R1
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap && !clr) |=> (cnt == '0));

  // R2
  halt_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (halt && !clr) |=> $stable(cnt));

  // R2
  halt_out_chk: assert property (@(posedge clk) disable iff (rst)
    (halt && !clr) |=> $stable(pwm_out));

  // R3
  clr_state_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0) && !act);

  // R9
  act_switch_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(act) |-> $past(wrap || clr || ctl_wr));

  // R8
  single_src_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_SINGLE) |-> !act);

  // R5
  out_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pwm_out) |-> $past(hit || wrap || clr));

endmodule

bind lpwm_top lpwm_chk #(.CW(2 * DW)) u_chk (
  .clk(clk), .rst(rst), .halt(halt), .clr(clr), .ctl_wr(ctl_wr),
  .wrap(wrap), .hit(hit), .act(act), .cnt(cnt), .mode(ch0_mode),
  .pwm_out(pwm_out)
);

// File: tb/tb_lpwm_top.sv
`timescale 1ns/1ps
module tb_lpwm_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out;

  int nchk = 0;
  int nfail = 0;
  int idx = 0;
  int hist [8];
  int hcnt;

  always #5 clk = ~clk;

  lpwm_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  typedef struct packed {
    logic [15:0] per;
    logic [15:0] cmp;
    logic        set;
    logic        tov;
    logic [15:0] exp;
  } vec_t;

  // high cycles expected over periods 1 and 2 of a single-channel run
  localparam vec_t VT [12] = '{
    '{16'd9,   16'd3,   1'b0, 1'b1, 16'd8},
    '{16'd9,   16'd0,   1'b0, 1'b1, 16'd2},
    '{16'd9,   16'd9,   1'b0, 1'b1, 16'd0},
    '{16'd9,   16'd20,  1'b0, 1'b1, 16'd10},
    '{16'd9,   16'd3,   1'b1, 1'b1, 16'd12},
    '{16'd9,   16'd9,   1'b1, 1'b1, 16'd20},
    '{16'd4,   16'd1,   1'b0, 1'b1, 16'd4},
    '{16'd15,  16'd7,   1'b1, 1'b1, 16'd16},
    '{16'd9,   16'd20,  1'b1, 1'b1, 16'd10},
    '{16'd9,   16'd3,   1'b0, 1'b0, 16'd0},
    '{16'd9,   16'd3,   1'b1, 1'b0, 16'd20},
    '{16'd256, 16'd128, 1'b0, 1'b1, 16'd258}
  };

  task automatic check(input string req, input int act_v, input int exp_v);
    nchk++;
    if (act_v != exp_v) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = 4'(a);
    wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr16(input int hi_a, input int v);
    wr(hi_a, (v >> 8) & 8'hFF);
    wr(hi_a + 1, v & 8'hFF);
  endtask

  // first sample taken in the cycle the counter shows 0
  task automatic watch(input int per, input int nper);
    for (int k = 0; k < 8; k++) hist[k] = 0;
    for (int i = 0; i < per * nper; i++) begin
      idx = i;
      if (pwm_out && (i / per) < 8) hist[i / per]++;
      @(negedge clk);
    end
    idx = per * nper;
  endtask

  task automatic restart();
    wr(0, 3);
    wr(0, 0);
  endtask

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 reset output", int'(pwm_out), 0);
    // set-on-match mode while halted from reset: nothing may move
    wr(7, 8'b000_11_1_01);
    hcnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_out) hcnt++;
    end
    check("R12 halted after reset", hcnt, 0);

    // R1 R5 R6 R7: table of single-channel cases
    for (int v = 0; v < 12; v++) begin
      wr(0, 1);
      wr16(1, int'(VT[v].per));
      wr16(3, int'(VT[v].cmp));
      wr(7, {3'b000, VT[v].set ? 2'b11 : 2'b10, VT[v].tov, 2'b01});
      restart();
      watch(int'(VT[v].per) + 1, 3);
      check($sformatf("R1/R5/R6/R7 vector %0d", v), hist[1] + hist[2], int'(VT[v].exp));
    end

    // R8: single mode ignores register 1 even when written last
    wr(0, 1);
    wr16(1, 9);
    wr(7, 8'b000_10_1_01);
    wr16(3, 2);
    wr16(5, 6);
    restart();
    watch(10, 3);
    check("R8 single mode period1", hist[1], 3);
    check("R8 single mode period2", hist[2], 3);

    // R9 R10 R11 R4: paired run with writes at chosen points
    wr(0, 1);
    wr16(3, 2);
    wr(7, 8'b000_10_1_10);
    restart();
    idx = 0;
    fork
      watch(10, 8);
      begin
        wait (idx >= 12); wr16(5, 6);
        wait (idx >= 22); wr(8, 8'hFF);
        wait (idx >= 32); wr16(3, 4);
        wait (idx >= 49); wr16(3, 7);
        wait (idx >= 62); wr(3, 8'h01);
      end
    join
    check("R9 register 0 first", hist[1], 3);
    check("R9 idle write at wrap", hist[2], 7);
    check("R11 second control ignored", hist[2], 7);
    check("R9 idle write deferred", hist[3], 7);
    check("R9 last written wins", hist[4], 5);
    check("R10 active write immediate", hist[5], 8);
    check("R4 lone high byte period6", hist[6], 8);
    check("R4 lone high byte period7", hist[7], 8);

    // R3: clear while running and high
    while (!pwm_out) @(negedge clk);
    wr(0, 2);
    check("R3 clear to idle level", int'(pwm_out), 0);
    watch(10, 2);
    check("R3 restart from zero", hist[1], 8);

    // R2: halt while high holds the level
    @(negedge clk);
    while (!pwm_out) @(negedge clk);
    wr(0, 1);
    hcnt = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pwm_out) hcnt++;
    end
    check("R2 halted output held", hcnt, 30);

    // R9: control write makes register 0 the latest again
    wr16(3, 2);
    wr16(5, 6);
    wr(7, 8'b000_10_1_10);
    restart();
    watch(10, 3);
    check("R9 pointer reset by control write", hist[1], 3);

    // R12: reset in the middle of a run
    @(negedge clk);
    while (!pwm_out) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R12 reset mid run", int'(pwm_out), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule